// File: doc/BRIEF.md
# Error-Tolerant Approximate Adder

This block is a purely combinational adder for two unsigned operands. It trades a small, one-sided arithmetic error for a much shorter carry path. A parameterised cut point divides each operand into two fields. The field above the cut is summed exactly with a ripple carry, and its carry-out becomes the top bit of the result. The field below the cut has no carry logic at all. The hardware walks that field from its most significant position downward. Each position gives the XOR of its two bits until the first position where both bits are 1. That position and every position below it are then driven to 1.

It suits datapaths where a small loss of precision is acceptable in return for a shorter critical path, such as pixel or audio accumulation. An enable input chooses between the approximate sum and a plain pass-through of the first operand, so the adder can sit in a bypassable stage. Setting the cut point to zero gives an exact adder.

Top module: `approx_err_tol_adder`

## Requirements
- R1: While `en` is 1, bits WIDTH down to LOW_W of `sum` equal the exact sum of `opa[WIDTH-1:LOW_W]` and `opb[WIDTH-1:LOW_W]`. No carry enters this field from below. `sum[WIDTH]` is the carry-out of this field.
- R2: While `en` is 1, each lower-field bit `sum[i]` (i < LOW_W) that lies above every position where both operand bits are 1 equals `opa[i] ^ opb[i]`. If no lower position has both bits at 1, the whole lower field is the XOR of the operands.
- R3: While `en` is 1, let k be the highest lower position where both operand bits are 1. Then `sum[k]` and every bit below it are 1.
- R4: While `en` is 0, `sum` equals `{1'b0, opa}`, whatever `opb` holds.
- R5: With WIDTH=8 and LOW_W=4, adding 8'b10110111 and 8'b10111101 gives 9'b101101111 (367), while the exact sum is 372.
- R6: With LOW_W=0, `sum` equals the exact sum `opa + opb` while `en` is 1.
- R7: While `en` is 1, `sum` is never greater than the exact sum. It equals the exact sum exactly when no lower position has both operand bits at 1.
- R8: An uneven split (LOW_W=3 with WIDTH=8) follows R1 to R3 with the cut at bit 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | WIDTH | First operand; passed through when disabled |
| opb | input | WIDTH | Second operand |
| en | input | 1 | 1 selects the approximate sum, 0 selects pass-through of `opa` |
| sum | output | WIDTH+1 | Approximate sum, or `{0, opa}` when disabled |

## Verification
The block holds no state, so any fault in the fill scan or the ripple chain shows at `sum` as soon as the operands settle. No later cycle can hide or delay it. A fill signal that is stuck low shows as a 0 below the highest double-1 position. A fill that starts one bit too high or too low changes one specific bit. A carry leaking across the cut raises the upper field and breaks the rule that the result never exceeds the exact sum. Operand patterns are chosen so that the highest double-1 position falls at each lower bit in turn, at the cut edge, and nowhere at all. Each pattern is applied to the default split, the exact configuration and the uneven split.

// File: rtl/eta_pkg.sv
`timescale 1ns/1ps
package eta_pkg;
  // Width of the accurate field for a given operand width and cut point.
  function automatic int unsigned hi_width(input int unsigned width, input int unsigned low_w);
    return (low_w >= width) ? 0 : width - low_w;
  endfunction
endpackage

// File: rtl/eta_upper_ripple.sv
`timescale 1ns/1ps
module eta_upper_ripple #(
  parameter int unsigned HI_W = 4
) (
  input  logic [HI_W-1:0] a_i,
  input  logic [HI_W-1:0] b_i,
  output logic [HI_W:0]   s_o
);
  // Exact ripple addition with no carry in from the lower field.
  always_comb begin
    logic c;
    c = 1'b0;
    for (int i = 0; i < int'(HI_W); i++) begin
      s_o[i] = a_i[i] ^ b_i[i] ^ c;
      c      = (a_i[i] & b_i[i]) | (c & (a_i[i] ^ b_i[i]));
    end
    s_o[HI_W] = c;
  end
endmodule

// File: rtl/eta_lower_fill.sv
`timescale 1ns/1ps
module eta_lower_fill #(
  parameter int unsigned LO_W = 4
) (
  input  logic [LO_W-1:0] a_i,
  input  logic [LO_W-1:0] b_i,
  output logic [LO_W-1:0] s_o
);
  // Scan from the top bit downward. Once a double-1 is seen, fill with ones.
  always_comb begin
    logic fill;
    fill = 1'b0;
    for (int i = int'(LO_W) - 1; i >= 0; i--) begin
      fill   = fill | (a_i[i] & b_i[i]);
      s_o[i] = fill | (a_i[i] ^ b_i[i]);
    end
  end
endmodule

// File: rtl/approx_err_tol_adder.sv
`timescale 1ns/1ps
module approx_err_tol_adder #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned LOW_W = WIDTH / 2
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic             en,
  output logic [WIDTH:0]   sum
);
  import eta_pkg::*;

  localparam int unsigned HI_W = hi_width(WIDTH, LOW_W);

  logic [WIDTH:0] approx;

  generate
    if (LOW_W == 0) begin : g_exact
      logic [WIDTH:0] hi_s;
      eta_upper_ripple #(.HI_W(WIDTH)) u_hi (.a_i(opa), .b_i(opb), .s_o(hi_s));
      assign approx = hi_s;
    end else if (HI_W == 0) begin : g_all_low
      logic [WIDTH-1:0] lo_s;
      eta_lower_fill #(.LO_W(WIDTH)) u_lo (.a_i(opa), .b_i(opb), .s_o(lo_s));
      assign approx = {1'b0, lo_s};
    end else begin : g_split
      logic [HI_W:0]  hi_s;
      logic [LOW_W-1:0] lo_s;
      eta_upper_ripple #(.HI_W(HI_W)) u_hi (
        .a_i(opa[WIDTH-1:LOW_W]), .b_i(opb[WIDTH-1:LOW_W]), .s_o(hi_s));
      eta_lower_fill #(.LO_W(LOW_W)) u_lo (
        .a_i(opa[LOW_W-1:0]), .b_i(opb[LOW_W-1:0]), .s_o(lo_s));
      assign approx = {hi_s, lo_s};
    end
  endgenerate

  // Output select: approximate sum or pass-through of the first operand.
  always_comb begin
    if (en) sum = approx;
    else    sum = {1'b0, opa};
  end
endmodule

// File: rtl/eta_adder_chk.sv
`timescale 1ns/1ps
module eta_adder_chk #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned LOW_W = WIDTH / 2
) (
  input logic [WIDTH-1:0] opa,
  input logic [WIDTH-1:0] opb,
  input logic             en,
  input logic [WIDTH:0]   sum
);
  localparam logic [WIDTH:0] ONES    = '1;
  localparam logic [WIDTH:0] LO_MASK = ~(ONES << LOW_W);

  logic [WIDTH:0] ea, eb, exact, both;
  always_comb begin
    ea    = {1'b0, opa};
    eb    = {1'b0, opb};
    exact = ea + eb;
    both  = ea & eb & LO_MASK;
    AST_UPPER_EXACT: assert (!en || ((sum >> LOW_W) == ((ea >> LOW_W) + (eb >> LOW_W)))) // R1
      else $error("upper field mismatch");
    AST_NO_HIT_XOR: assert (!en || (both != '0) || ((sum & LO_MASK) == ((ea ^ eb) & LO_MASK))) // R2
      else $error("lower field not xor");
    AST_FILL_BOTTOM: assert (!en || (both == '0) || sum[0]) // R3
      else $error("fill did not reach bit 0");
    AST_BYPASS: assert (en || (sum == ea)) // R4
      else $error("bypass mismatch");
    AST_EXACT_CFG: assert (!en || (LOW_W != 0) || (sum == exact)) // R6
      else $error("exact configuration mismatch");
    AST_NOT_ABOVE_EXACT: assert (!en || (sum <= exact)) // R7
      else $error("result above exact sum");
  end
endmodule

bind approx_err_tol_adder eta_adder_chk #(.WIDTH(WIDTH), .LOW_W(LOW_W)) u_chk (
  .opa(opa), .opb(opb), .en(en), .sum(sum));

// File: tb/sim_approx_err_tol_adder.sv
`timescale 1ns/1ps
module sim_approx_err_tol_adder;
  logic clk;
  logic [7:0] a, b;
  logic en;
  logic [8:0] s0, s1, s2;
  int checks = 0;
  int errors = 0;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  approx_err_tol_adder #(.WIDTH(8), .LOW_W(4)) u0 (.opa(a), .opb(b), .en(en), .sum(s0));
  approx_err_tol_adder #(.WIDTH(8), .LOW_W(0)) u1 (.opa(a), .opb(b), .en(en), .sum(s1));
  approx_err_tol_adder #(.WIDTH(8), .LOW_W(3)) u2 (.opa(a), .opb(b), .en(en), .sum(s2));

  // Behavioural reference model.
  function automatic int model(int x, int y, bit e, int low);
    int hi, lo, run;
    if (!e) return x;
    hi = (x >> low) + (y >> low);
    lo = 0; run = 0;
    for (int i = low - 1; i >= 0; i--) begin
      int xb, yb;
      xb = (x >> i) & 1; yb = (y >> i) & 1;
      if (xb == 1 && yb == 1) run = 1;
      lo = lo | ((run | (xb ^ yb)) << i);
    end
    return (hi << low) | lo;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s a=%0d b=%0d en=%0b actual=%0d expected=%0d", tag, a, b, en, act, exp);
    end
  endtask

  // Per-field checks for one instance with cut point low.
  task automatic check_fields(int act, int low, string split_tag);
    int exp, hit, mask;
    exp  = model(a, b, en, low);
    mask = (1 << low) - 1;
    hit  = a & b & mask;
    if (!en) begin
      check("R4", act, int'(a));
      return;
    end
    check({"R1", split_tag}, act >> low, exp >> low);
    if (hit != 0) check({"R3", split_tag}, act & mask, exp & mask);
    else          check({"R2", split_tag}, act & mask, (a ^ b) & mask);
  endtask

  task automatic apply(logic [7:0] x, logic [7:0] y, logic e);
    int ex;
    @(posedge clk); #1;
    a = x; b = y; en = e;
    @(negedge clk);
    ex = int'(x) + int'(y);
    check_fields(int'(s0), 4, "");
    check_fields(int'(s2), 3, " R8");
    if (e) begin
      check("R6", int'(s1), ex);
      check("R7", int'(s0 <= 9'(ex)), 1);
      check("R7", int'(s0 == 9'(ex)), int'((x & y & 8'h0f) == 0));
    end else begin
      check("R4", int'(s1), int'(x));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    a = '0; b = '0; en = 1'b0;
    @(negedge clk);
    check("R4", int'(s0), 0);                      // idle pass-through state
    apply(8'b10110111, 8'b10111101, 1'b1);
    check("R5", int'(s0), 367);                    // worked example
    check("R5", int'(s1), 372);
    apply(8'h00, 8'h00, 1'b1);
    apply(8'hff, 8'hff, 1'b1);
    check("R3", int'(s0), 495);
    apply(8'hf5, 8'h0a, 1'b1);                     // no double-1 anywhere
    apply(8'h88, 8'h88, 1'b1);                     // double-1 at lower MSB
    apply(8'h01, 8'h01, 1'b1);                     // double-1 at bit 0
    apply(8'h0f, 8'h01, 1'b1);
    apply(8'h7c, 8'h5a, 1'b0);
    apply(8'hff, 8'h00, 1'b0);
    for (int k = 0; k < 8; k++) begin
      apply(8'(1 << k), 8'(1 << k), 1'b1);
      apply(8'((1 << k) | 8'h50), 8'(8'hff >> (7 - k)), 1'b1);
    end
    for (int n = 0; n < 600; n++) apply(8'($urandom), 8'($urandom), 1'($urandom % 5 != 0));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule